// File: doc/BRIEF.md
# Window-Decoded Register Operation Bridge

This block sits between a CPU-side memory-mapped port and a local bank of 32-bit control registers. The CPU never issues a command word: the kind of operation is chosen by which address window the access falls in. One window gives plain read and write access, two windows OR bits in or strip bits out, and three windows perform masked writes on a nibble, a byte or a halfword, where a single bus operand carries both the mask and the new field value.

Every write becomes a read-modify-write of one register. The bridge decodes the window and the register index, moves the operand down from its byte lane, builds the field mask, merges the new bits into the old value, and rejects any access whose size, alignment or window is not allowed. An optional wait-for-acknowledge mode holds off the CPU for one extra cycle before each access completes. Without it, writes are posted in a single cycle.

Top module: `winop_reg_bridge`

## Requirements
- R1: Bits 10:7 of the address select the window: 0 direct, 1 set, 2 clear, 4-5 nibble-masked, 6-7 byte-masked, 8-9 halfword-masked (bases 0x000, 0x080, 0x100, 0x200, 0x300, 0x400). In the direct, set and clear windows the register index is address bits 6:2. In the masked windows it is address bits 7:3. Window code 3 (0x180-0x1FF) and codes 10-15 (0x500 and above) decode to no window.
- R2: A direct write changes only the bytes it covers. Size code 0 is a byte, 1 a halfword and 2 a word. Write data sits on its byte lane: a byte at address bits 1:0 = k is on wdata[8k+7:8k], and a halfword at +2 is on wdata[31:16]. No other register changes.
- R3: A set-window write ORs the lane-placed operand into the register. It accepts byte, halfword and word sizes.
- R4: A clear-window write clears every register bit that is 1 in the lane-placed operand. It accepts byte, halfword and word sizes.
- R5: A halfword-masked write is a word access. The operand's bits 31:16 are the mask and bits 15:0 are the data. Slot offset +0 targets register bits 15:0 and +4 targets bits 31:16.
- R6: A byte-masked write is a halfword access whose operand has the mask in bits 15:8 and the data in bits 7:0. Slot offset 2k targets register byte k.
- R7: A nibble-masked write is a byte access whose operand has the mask in bits 7:4 and the data in bits 3:0. Slot offset n (0-7) targets register nibble n.
- R8: A masked write changes only the register bits whose mask bit is 1.
- R9: Reads are served only by the direct window, as byte or halfword accesses. rsp_rdata carries the selected lanes at their lane positions and zero elsewhere.
- R10: An access is an error and sets rsp_err, returns zero read data and changes no register in any of these cases: a read outside the direct window, a word read, a halfword at an odd address, a word not 4-aligned, size code 3, a masked write of the wrong size, an unmapped window, or an index at or above NREG.
- R11: With wait_ack_en low, req_ready rises in the same cycle as req_valid, and a write is visible to a read in the next cycle.
- R12: With wait_ack_en high (and HAS_WAIT set), req_ready stays low for the first cycle of an access and rises in the second cycle. A write is committed at the end of that second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears every register to RESET_VAL |
| wait_ack_en | input | 1 | Wait-for-acknowledge mode enable |
| req_valid | input | 1 | Access request present; held until req_ready |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 11 | Byte address inside the bridge window space |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_wdata | input | 32 | Lane-placed write operand |
| req_ready | output | 1 | Access completes in this cycle |
| rsp_rdata | output | 32 | Lane-placed read data, valid with req_ready on a read |
| rsp_err | output | 1 | Access rejected, valid with req_ready |

## Verification
Direct writes of a word, then a halfword on the upper lane, then a byte on lane 1, tell apart a correct byte-enable expansion from one that writes whole words or takes the operand from the wrong lane. Set and clear are each tried with a full word and with a narrow upper-lane operand, so that a swapped OR/AND-NOT or an unshifted operand gives a different register value. The masked windows are tried at both halves, at the high bytes and at the high nibbles, each with full and partial masks on a register preloaded with all ones, which exposes wrong slot scaling, swapped mask and data fields, and mask leakage. Each illegal access class is followed by a read-back of the register it would have hit, and the access latency is counted in both wait modes.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

   localparam int ADDR_W    = 11;
   localparam int DATA_W    = 32;
   localparam int WIN_SLOTS = 32;
   localparam int IDX_W     = $clog2(WIN_SLOTS);

   typedef enum logic [2:0] {
      WIN_DIR, WIN_SET, WIN_CLR, WIN_MSK4, WIN_MSK8, WIN_MSK16, WIN_NONE
   } win_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_BAD = 2'd3
   } size_e;

   function automatic logic [DATA_W-1:0] lanes_to_bits(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

endpackage

// File: rtl/wbr_decode.sv
module wbr_decode
   import wbr_pkg::*;
#(
   parameter int NREG = 32
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              write,
   output win_e              win,
   output logic [IDX_W-1:0]  idx,
   output logic [3:0]        be,
   output logic              err
);

   size_e sz;
   logic  align_ok;
   logic  size_ok;
   logic  idx_ok;

   assign sz = size_e'(size);

   always_comb begin
      win = WIN_NONE;
      idx = addr[6:2];
      unique case (addr[10:7])
         4'd0:       win = WIN_DIR;
         4'd1:       win = WIN_SET;
         4'd2:       win = WIN_CLR;
         4'd4, 4'd5: begin win = WIN_MSK4;  idx = addr[7:3]; end
         4'd6, 4'd7: begin win = WIN_MSK8;  idx = addr[7:3]; end
         4'd8, 4'd9: begin win = WIN_MSK16; idx = addr[7:3]; end
         default:    win = WIN_NONE;
      endcase
   end

   always_comb begin
      unique case (sz)
         SZ_BYTE: be = 4'b0001 << addr[1:0];
         SZ_HALF: be = addr[1] ? 4'b1100 : 4'b0011;
         SZ_WORD: be = 4'b1111;
         default: be = 4'b0000;
      endcase
   end

   assign align_ok = (sz == SZ_BYTE) ||
                     (sz == SZ_HALF && !addr[0]) ||
                     (sz == SZ_WORD && addr[1:0] == 2'b00);

   always_comb begin
      unique case (win)
         WIN_DIR:          size_ok = write ? (sz != SZ_BAD)
                                           : (sz == SZ_BYTE || sz == SZ_HALF);
         WIN_SET, WIN_CLR: size_ok = write && (sz != SZ_BAD);
         WIN_MSK4:         size_ok = write && (sz == SZ_BYTE);
         WIN_MSK8:         size_ok = write && (sz == SZ_HALF);
         WIN_MSK16:        size_ok = write && (sz == SZ_WORD);
         default:          size_ok = 1'b0;
      endcase
   end

   assign idx_ok = ({1'b0, idx} < (IDX_W+1)'(NREG));
   assign err    = !(size_ok && align_ok && idx_ok);

   always_comb begin
      AST_BAD_SIZE_REJECTED: assert (!(sz == SZ_BAD && !err)); // R10
   end

endmodule

// File: rtl/wbr_merge.sv
module wbr_merge
   import wbr_pkg::*;
(
   input  win_e              win,
   input  logic [2:0]        slot_off,
   input  logic [3:0]        be,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] old_val,
   output logic [DATA_W-1:0] fld,
   output logic [DATA_W-1:0] new_val
);

   logic [7:0]        op8;
   logic [15:0]       op16;
   logic [DATA_W-1:0] lane_bits;
   logic [DATA_W-1:0] dat;

   assign op8       = wdata[{slot_off[1:0], 3'b000} +: 8];
   assign op16      = slot_off[1] ? wdata[31:16] : wdata[15:0];
   assign lane_bits = lanes_to_bits(be);

   always_comb begin
      unique case (win)
         WIN_DIR: begin fld = lane_bits;         dat = wdata; end
         WIN_SET: begin fld = wdata & lane_bits; dat = '1;    end
         WIN_CLR: begin fld = wdata & lane_bits; dat = '0;    end
         WIN_MSK4: begin
            fld = DATA_W'(op8[7:4]) << {slot_off, 2'b00};
            dat = DATA_W'(op8[3:0]) << {slot_off, 2'b00};
         end
         WIN_MSK8: begin
            fld = DATA_W'(op16[15:8]) << {slot_off[2:1], 3'b000};
            dat = DATA_W'(op16[7:0])  << {slot_off[2:1], 3'b000};
         end
         WIN_MSK16: begin
            fld = DATA_W'(wdata[31:16]) << {slot_off[2], 4'b0000};
            dat = DATA_W'(wdata[15:0])  << {slot_off[2], 4'b0000};
         end
         default: begin fld = '0; dat = '0; end
      endcase
   end

   assign new_val = (old_val & ~fld) | (dat & fld);

endmodule

// File: rtl/wbr_regfile.sv
module wbr_regfile
   import wbr_pkg::*;
#(
   parameter int                NREG      = 32,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [IDX_W-1:0]                  widx,
   input  logic [DATA_W-1:0]                 wval,
   output logic [WIN_SLOTS-1:0][DATA_W-1:0]  q_all
);

   for (genvar i = 0; i < WIN_SLOTS; i++) begin : g_slot
      if (i < NREG) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q_all[i] <= RESET_VAL;
            else if (we && widx == IDX_W'(i))
               q_all[i] <= wval;
         end

         AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && widx == IDX_W'(i)) |=> $stable(q_all[i])); // R2
      end else begin : g_absent
         assign q_all[i] = '0;
      end
   end

endmodule

// File: rtl/winop_reg_bridge.sv
module winop_reg_bridge
   import wbr_pkg::*;
#(
   parameter int                NREG      = 32,
   parameter bit                HAS_WAIT  = 1'b1,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wait_ack_en,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [10:0]       req_addr,
   input  logic [1:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic              req_ready,
   output logic [31:0]       rsp_rdata,
   output logic              rsp_err
);

   if (NREG < 1 || NREG > WIN_SLOTS) begin : g_bad_nreg
      $error("NREG must lie in 1..WIN_SLOTS");
   end
   if (ADDR_W != 11 || DATA_W != 32) begin : g_bad_geom
      $error("window layout assumes 11 address bits and 32 data bits");
   end

   win_e                             win;
   logic [IDX_W-1:0]                 idx;
   logic [3:0]                       be;
   logic                             dec_err;
   logic [WIN_SLOTS-1:0][DATA_W-1:0] q_all;
   logic [DATA_W-1:0]                old_val;
   logic [DATA_W-1:0]                fld;
   logic [DATA_W-1:0]                new_val;
   logic                             stall_q;
   logic                             wr_en;

   wbr_decode #(.NREG(NREG)) u_decode (
      .addr  (req_addr),
      .size  (req_size),
      .write (req_write),
      .win   (win),
      .idx   (idx),
      .be    (be),
      .err   (dec_err)
   );

   assign old_val = q_all[idx];

   wbr_merge u_merge (
      .win      (win),
      .slot_off (req_addr[2:0]),
      .be       (be),
      .wdata    (req_wdata),
      .old_val  (old_val),
      .fld      (fld),
      .new_val  (new_val)
   );

   if (HAS_WAIT) begin : g_wait
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stall_q <= 1'b0;
         else        stall_q <= req_valid && wait_ack_en && !stall_q;
      end

      AST_WAIT_FIRST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(req_valid) && wait_ack_en |-> !req_ready); // R12
      AST_WAIT_ONE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid && !req_ready && wait_ack_en |=> !req_valid || req_ready); // R12
   end else begin : g_posted
      assign stall_q = 1'b1;
   end

   assign req_ready = req_valid && (!wait_ack_en || stall_q);
   assign wr_en     = req_ready && req_write && !dec_err;
   assign rsp_err   = req_valid && dec_err;
   assign rsp_rdata = (req_valid && !req_write && !dec_err)
                      ? (old_val & lanes_to_bits(be)) : '0;

   wbr_regfile #(.NREG(NREG), .RESET_VAL(RESET_VAL)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .widx  (idx),
      .wval  (new_val),
      .q_all (q_all)
   );

   AST_POSTED_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !wait_ack_en |-> req_ready); // R11
   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_rdata == '0); // R10
   AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready && rsp_err |=> $stable(q_all)); // R10
   AST_SET_ONLY_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && win == WIN_SET |=>
      (q_all[$past(idx)] & $past(old_val)) == $past(old_val)); // R3
   AST_CLR_ONLY_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && win == WIN_CLR |=>
      (q_all[$past(idx)] & ~$past(old_val)) == '0); // R4
   AST_MASK_CONFINED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (win == WIN_MSK4 || win == WIN_MSK8 || win == WIN_MSK16) |=>
      ((q_all[$past(idx)] ^ $past(old_val)) & ~$past(fld)) == '0); // R8

endmodule

// File: tb/winop_reg_bridge_tb.sv
`timescale 1ns/1ps
module winop_reg_bridge_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wait_ack_en = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [10:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready;
   logic [31:0] rsp_rdata;
   logic        rsp_err;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   winop_reg_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .wait_ack_en(wait_ack_en),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, got, exp);
      end
   endtask

   task automatic xfer(input logic wr, input logic [10:0] addr, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd,
                       output logic e, output int n);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr;
      req_size = sz; req_wdata = wd;
      #2;
      n = 1;
      while (!req_ready && n < 8) begin
         @(negedge clk); #2; n++;
      end
      rd = rsp_rdata; e = rsp_err;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic wr(input logic [10:0] addr, input logic [1:0] sz, input logic [31:0] wd);
      logic [31:0] rd; logic e; int n;
      xfer(1'b1, addr, sz, wd, rd, e, n);
   endtask

   task automatic read_reg(input int idx, output logic [31:0] val);
      logic [31:0] r0, r1; logic e0, e1; int n;
      xfer(1'b0, 11'(idx * 4), 2'd1, '0, r0, e0, n);
      xfer(1'b0, 11'(idx * 4 + 2), 2'd1, '0, r1, e1, n);
      val = {r1[31:16], r0[15:0]};
   endtask

   task automatic t_reset;
      logic [31:0] rd; logic e; int n;
      chk("R11 ready idle low", {31'b0, req_ready}, 32'd0);
      xfer(1'b0, 11'h000, 2'd1, '0, rd, e, n);
      chk("R9 reset read zero", rd, 32'h0);
      chk("R11 posted read latency", n, 1);
   endtask

   task automatic t_direct;
      logic [31:0] v, rd; logic e; int n;
      wr(11'h00C, 2'd2, 32'h1234_5678);
      read_reg(3, v); chk("R2 word write", v, 32'h1234_5678);
      wr(11'h00E, 2'd1, 32'hABCD_0000);
      read_reg(3, v); chk("R2 upper half write", v, 32'hABCD_5678);
      wr(11'h00D, 2'd0, 32'h0000_6600);
      read_reg(3, v); chk("R2 byte lane1 write", v, 32'hABCD_6678);
      read_reg(2, v); chk("R2 neighbour untouched", v, 32'h0);
      xfer(1'b0, 11'h00F, 2'd0, '0, rd, e, n);
      chk("R9 byte read lane3", rd, 32'hAB00_0000);
      xfer(1'b0, 11'h00D, 2'd0, '0, rd, e, n);
      chk("R9 byte read lane1", rd, 32'h0000_6600);
   endtask

   task automatic t_setclr;
      logic [31:0] v;
      wr(11'h090, 2'd2, 32'hAAAA_AAAA);
      read_reg(4, v); chk("R3 set word", v, 32'hAAAA_AAAA);
      wr(11'h092, 2'd0, 32'h0055_0000);
      read_reg(4, v); chk("R3 set byte lane2", v, 32'hAAFF_AAAA);
      wr(11'h110, 2'd2, 32'h00FF_0000);
      read_reg(4, v); chk("R4 clear word", v, 32'hAA00_AAAA);
      wr(11'h112, 2'd1, 32'h8000_0000);
      read_reg(4, v); chk("R4 clear upper half", v, 32'h2A00_AAAA);
   endtask

   task automatic t_masked;
      logic [31:0] v;
      wr(11'h43C, 2'd2, 32'h01FF_01AA);
      read_reg(7, v); chk("R5 m16 upper half", v, 32'h01AA_0000);
      wr(11'h438, 2'd2, 32'hFFFF_5555);
      read_reg(7, v); chk("R5 m16 lower half", v, 32'h01AA_5555);
      wr(11'h024, 2'd2, 32'hFFFF_FFFF);
      wr(11'h34A, 2'd1, 32'hFF11_0000);
      read_reg(9, v); chk("R6 m8 byte1", v, 32'hFFFF_11FF);
      wr(11'h34E, 2'd1, 32'hFF33_0000);
      read_reg(9, v); chk("R6 m8 byte3", v, 32'h33FF_11FF);
      wr(11'h348, 2'd1, 32'h0000_0F05);
      read_reg(9, v); chk("R8 m8 partial mask", v, 32'h33FF_11F5);
      wr(11'h028, 2'd2, 32'hFFFF_FFFF);
      wr(11'h250, 2'd0, 32'h0000_00F7);
      read_reg(10, v); chk("R7 m4 nibble0", v, 32'hFFFF_FFF7);
      wr(11'h255, 2'd0, 32'h0000_3400);
      read_reg(10, v); chk("R8 m4 nibble5 partial", v, 32'hFFCF_FFF7);
      wr(11'h257, 2'd0, 32'hF000_0000);
      read_reg(10, v); chk("R7 m4 nibble7", v, 32'h0FCF_FFF7);
   endtask

   task automatic t_errors;
      logic [31:0] v, rd; logic e; int n;
      xfer(1'b0, 11'h08C, 2'd1, '0, rd, e, n);
      chk("R10 read set window err", {31'b0, e}, 32'd1);
      chk("R10 read set window data", rd, 32'h0);
      xfer(1'b0, 11'h00C, 2'd2, '0, rd, e, n);
      chk("R10 word read err", {31'b0, e}, 32'd1);
      chk("R10 word read data", rd, 32'h0);
      xfer(1'b0, 11'h00D, 2'd1, '0, rd, e, n);
      chk("R10 odd half read err", {31'b0, e}, 32'd1);
      xfer(1'b1, 11'h418, 2'd1, 32'h0000_FFFF, rd, e, n);
      chk("R10 m16 half err", {31'b0, e}, 32'd1);
      xfer(1'b1, 11'h318, 2'd0, 32'h0000_00FF, rd, e, n);
      chk("R10 m8 byte err", {31'b0, e}, 32'd1);
      xfer(1'b1, 11'h218, 2'd1, 32'h0000_FFFF, rd, e, n);
      chk("R10 m4 half err", {31'b0, e}, 32'd1);
      xfer(1'b1, 11'h00C, 2'd3, 32'hFFFF_FFFF, rd, e, n);
      chk("R10 size3 err", {31'b0, e}, 32'd1);
      xfer(1'b1, 11'h00E, 2'd2, 32'hFFFF_FFFF, rd, e, n);
      chk("R10 misaligned word err", {31'b0, e}, 32'd1);
      xfer(1'b1, 11'h18C, 2'd2, 32'hFFFF_FFFF, rd, e, n);
      chk("R1 gap window err", {31'b0, e}, 32'd1);
      xfer(1'b1, 11'h50C, 2'd2, 32'hFFFF_FFFF, rd, e, n);
      chk("R1 above windows err", {31'b0, e}, 32'd1);
      read_reg(3, v); chk("R10 reg3 unchanged", v, 32'hABCD_6678);
   endtask

   task automatic t_wait;
      logic [31:0] v, rd; logic e; int n;
      wait_ack_en = 1'b1;
      xfer(1'b1, 11'h014, 2'd2, 32'hCAFE_F00D, rd, e, n);
      chk("R12 write latency", n, 2);
      xfer(1'b0, 11'h014, 2'd1, '0, rd, e, n);
      chk("R12 read latency", n, 2);
      chk("R12 committed data", rd, 32'h0000_F00D);
      wait_ack_en = 1'b0;
      xfer(1'b1, 11'h016, 2'd1, 32'h1357_0000, rd, e, n);
      chk("R11 posted write latency", n, 1);
      read_reg(5, v); chk("R11 posted write visible", v, 32'h1357_F00D);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_direct();
      t_setclr();
      t_masked();
      t_errors();
      t_wait();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule